// File: doc/BRIEF.md
# Lockable Instruction Cache

This block is a read-only cache for instruction fetches. It sits between a fetch port and a word-wide backing memory. Nothing ever writes instruction data into it except its own line fills. A fetch that hits returns its word on the cycle after it is accepted. A fetch that misses reads the whole eight-word line from memory, stores the line and then returns the requested word. All addresses on both ports are word addresses: bits 31 down to 2 of the byte address.

The cache has 32 sets of four ways and 32-byte lines, so the set index repeats every 1024 bytes. Each set keeps a round-robin pointer for choosing a victim, and that choice skips any way that has been pinned. A fetch issued with the lock flag raised always reloads its line from memory and pins the line in place. An unlock pulse removes every pin. An invalidate pulse empties the whole cache. When the enable input is low, every fetch becomes a single-word memory read and nothing is stored.

Top module: `icache_lockable`

## Requirements
- R1: On a miss with the cache enabled, the block reads eight words at word addresses {addr[29:3], 0} through {addr[29:3], 7} in increasing order, one handshake each, and then returns the requested word.
- R2: A fetch that hits, without the lock flag, raises respValid with the correct word on the cycle after acceptance and makes no memory request.
- R3: fetchReady stays low from the acceptance of a fetch that needs memory until its response is given.
- R4: The set index is word-address bits [7:3] and the tag is bits [29:8]. Addresses 1024 bytes apart share a set. Lines in different sets never evict each other.
- R5: The victim in a set is the first unlocked way found by searching upward, with wraparound, from that set's pointer. After each such allocation the pointer moves to the victim plus one, modulo 4.
- R6: With cacheEn low, each fetch makes exactly one memory read at its own word address. It returns that word and allocates nothing.
- R7: A fetch with fetchLock high always refetches all eight words, even when the line is present, and pins the line. A pinned line is never chosen as a victim.
- R8: When all four ways of the target set are pinned, a miss is served by one memory read and allocates nothing.
- R9: A one-cycle unlockAll pulse clears every pin, and the lines stay valid.
- R10: A one-cycle invalidateAll pulse clears every valid bit and every pin.
- R11: After reset, no line is valid or pinned, every pointer is zero, fetchReady is high, and respValid and memReqValid are low.
- R12: While memReqValid is high and memReqReady is low, the request and its address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cacheEn | input | 1 | Cache enable; low means every fetch bypasses to memory |
| unlockAll | input | 1 | Pulse that clears every pin |
| invalidateAll | input | 1 | Pulse that clears every valid bit and pin |
| fetchValid | input | 1 | Fetch request valid |
| fetchReady | output | 1 | Fetch port can accept a request |
| fetchLock | input | 1 | Request is a lock-fill |
| fetchAddr | input | 30 | Fetch word address |
| respValid | output | 1 | Response word valid (one cycle) |
| respData | output | 32 | Response instruction word |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 30 | Memory read word address |
| memRspValid | input | 1 | Memory read data valid |
| memRspData | input | 32 | Memory read data |

## Verification
Fetches are aimed at one set with five addresses spaced 1024 bytes apart. The resulting hit and miss pattern tells round-robin eviction apart from least-recently-used: a line that was just reused still gets evicted. Lock-fills are mixed with ordinary misses in one set, which shows that pinned ways are skipped and kept. Fully pinning a second set shows the single-read fallback. Fetches with the cache disabled, and fetches after unlock and invalidate pulses, are told apart from normal ones by counting the memory reads and checking the read addresses each fetch produces.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // fetch accepted: latch request and lookup result
    logic hitResp;   // load response from the data array
    logic fillWord;  // one memory word has arrived
    logic fillLast;  // final word of the transfer: commit line state
  } dpStrobe_t;

endpackage

// File: rtl/icache_datapath.sv
module icache_datapath #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 32,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   cacheEn,
  input  logic                                   unlockAll,
  input  logic                                   invalidateAll,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]     fetchAddr,
  input  logic                                   fetchLock,
  input  icache_pkg::dpStrobe_t                  stb,
  input  logic [$clog2(LINE_WORDS)-1:0]          fillBeat,
  input  logic [DATA_W-1:0]                      memRspData,
  output logic                                   lkHit,
  output logic                                   reqAlloc,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     reqAddr,
  output logic [DATA_W-1:0]                      respData
);

  localparam int BYTE_W  = $clog2(DATA_W/8);
  localparam int WADDR_W = ADDR_W - BYTE_W;
  localparam int BEAT_W  = $clog2(LINE_WORDS);
  localparam int IDX_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int TAG_LSB = BEAT_W + IDX_W;
  localparam int TAG_W   = WADDR_W - TAG_LSB;
  localparam int LOC_W   = IDX_W + WAY_W + BEAT_W;
  localparam int DEPTH   = SETS * WAYS * LINE_WORDS;

  logic [WAYS-1:0]   validQ [SETS];
  logic [WAYS-1:0]   lockQ  [SETS];
  logic [WAY_W-1:0]  ptrQ   [SETS];
  logic [TAG_W-1:0]  tagQ   [SETS][WAYS];
  logic [DATA_W-1:0] dataQ  [DEPTH];

  // live lookup on the incoming fetch
  logic [IDX_W-1:0]  lkSet;
  logic [TAG_W-1:0]  lkTag;
  logic [BEAT_W-1:0] lkWord;
  logic [WAY_W-1:0]  lkHitWay;
  logic [WAY_W-1:0]  lkVictim;
  logic [WAY_W-1:0]  cand;
  logic              lkAllLocked;

  assign lkSet       = fetchAddr[BEAT_W +: IDX_W];
  assign lkTag       = fetchAddr[WADDR_W-1:TAG_LSB];
  assign lkWord      = fetchAddr[BEAT_W-1:0];
  assign lkAllLocked = &lockQ[lkSet];

  always_comb begin
    lkHit    = 1'b0;
    lkHitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (validQ[lkSet][w] && (tagQ[lkSet][w] == lkTag)) begin
        lkHit    = 1'b1;
        lkHitWay = WAY_W'(w);
      end
    end
  end

  // round-robin search from the set pointer, skipping pinned ways
  always_comb begin
    lkVictim = ptrQ[lkSet];
    cand     = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      cand = ptrQ[lkSet] + WAY_W'(i);
      if (!lockQ[lkSet][cand]) lkVictim = cand;
    end
  end

  // captured request
  logic [WADDR_W-1:0] reqAddrQ;
  logic               reqLockQ;
  logic               reqAllocQ;
  logic               reqAdvQ;
  logic [WAY_W-1:0]   reqWayQ;
  logic [IDX_W-1:0]   reqSet;
  logic [TAG_W-1:0]   reqTag;
  logic [BEAT_W-1:0]  reqWord;

  assign reqSet   = reqAddrQ[BEAT_W +: IDX_W];
  assign reqTag   = reqAddrQ[WADDR_W-1:TAG_LSB];
  assign reqWord  = reqAddrQ[BEAT_W-1:0];
  assign reqAddr  = reqAddrQ;
  assign reqAlloc = reqAllocQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddrQ  <= '0;
      reqLockQ  <= 1'b0;
      reqAllocQ <= 1'b0;
      reqAdvQ   <= 1'b0;
      reqWayQ   <= '0;
    end else if (stb.capture) begin
      reqAddrQ  <= fetchAddr;
      reqLockQ  <= fetchLock;
      reqAllocQ <= cacheEn && (lkHit || !lkAllLocked);
      reqAdvQ   <= !lkHit;
      reqWayQ   <= lkHit ? lkHitWay : lkVictim;
    end
  end

  logic [LOC_W-1:0] lkLoc;
  logic [LOC_W-1:0] fillLoc;
  assign lkLoc   = {lkSet, lkHitWay, lkWord};
  assign fillLoc = {reqSet, reqWayQ, fillBeat};

  always_ff @(posedge clk) begin
    if (stb.fillWord && reqAllocQ) dataQ[fillLoc] <= memRspData;
  end

  always_ff @(posedge clk) begin
    if (stb.fillLast && reqAllocQ) tagQ[reqSet][reqWayQ] <= reqTag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respData <= '0;
    end else if (stb.hitResp) begin
      respData <= dataQ[lkLoc];
    end else if (stb.fillWord && (!reqAllocQ || fillBeat == reqWord)) begin
      respData <= memRspData;
    end
  end

  // line state; the global pulses take priority over a commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        lockQ[s]  <= '0;
        ptrQ[s]   <= '0;
      end
    end else begin
      if (stb.fillLast && reqAllocQ) begin
        validQ[reqSet][reqWayQ] <= 1'b1;
        if (reqLockQ) lockQ[reqSet][reqWayQ] <= 1'b1;
        if (reqAdvQ)  ptrQ[reqSet] <= reqWayQ + WAY_W'(1);
      end
      if (unlockAll || invalidateAll) begin
        for (int s = 0; s < SETS; s++) lockQ[s] <= '0;
      end
      if (invalidateAll) begin
        for (int s = 0; s < SETS; s++) validQ[s] <= '0;
      end
    end
  end

  // ---------------- assertions ----------------
  logic anyValid;
  logic anyLock;
  always_comb begin
    anyValid = 1'b0;
    anyLock  = 1'b0;
    for (int s = 0; s < SETS; s++) begin
      anyValid = anyValid | (|validQ[s]);
      anyLock  = anyLock  | (|lockQ[s]);
    end
  end

  assert_unlock_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    unlockAll |=> !anyLock);

  assert_invalidate_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    invalidateAll |=> (!anyValid && !anyLock));

  assert_victim_unpinned_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fillLast && reqAllocQ && reqAdvQ) |-> !lockQ[reqSet][reqWayQ]);

  assert_pinned_line_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fillLast && reqAllocQ && reqAdvQ && !unlockAll && !invalidateAll)
      |=> $stable(lockQ[$past(reqSet)]) || $rose(lockQ[$past(reqSet)][$past(reqWayQ)]));

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                cacheEn,
  input  logic                                fetchValid,
  input  logic                                fetchLock,
  input  logic                                lkHit,
  input  logic                                reqAlloc,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]  reqAddr,
  input  logic                                memReqReady,
  input  logic                                memRspValid,
  output logic                                fetchReady,
  output logic                                respValid,
  output logic                                memReqValid,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]  memReqAddr,
  output icache_pkg::dpStrobe_t               stb,
  output logic [$clog2(LINE_WORDS)-1:0]       fillBeat
);

  import icache_pkg::*;

  localparam int BYTE_W  = $clog2(DATA_W/8);
  localparam int WADDR_W = ADDR_W - BYTE_W;
  localparam int BEAT_W  = $clog2(LINE_WORDS);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LINE_WORDS - 1);

  ctlState_t         state, nextState;
  logic [BEAT_W-1:0] beatQ;
  logic              respValidQ;

  assign fillBeat  = beatQ;
  assign respValid = respValidQ;

  always_comb begin
    stb         = '0;
    nextState   = state;
    fetchReady  = (state == ST_IDLE);
    memReqValid = (state == ST_REQ);
    memReqAddr  = reqAlloc ? {reqAddr[WADDR_W-1:BEAT_W], beatQ} : reqAddr;
    unique case (state)
      ST_IDLE: begin
        if (fetchValid) begin
          stb.capture = 1'b1;
          if (cacheEn && !fetchLock && lkHit) stb.hitResp = 1'b1;
          else                                nextState   = ST_REQ;
        end
      end
      ST_REQ: begin
        if (memReqReady) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          stb.fillWord = 1'b1;
          if (!reqAlloc || beatQ == LAST_BEAT) begin
            stb.fillLast = 1'b1;
            nextState    = ST_IDLE;
          end else begin
            nextState = ST_REQ;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      beatQ      <= '0;
      respValidQ <= 1'b0;
    end else begin
      state      <= nextState;
      respValidQ <= stb.hitResp || stb.fillLast;
      if (stb.capture)       beatQ <= '0;
      else if (stb.fillWord) beatQ <= beatQ + BEAT_W'(1);
    end
  end

  // ---------------- assertions ----------------
  assert_req_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  assert_busy_after_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !fetchReady);

  assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchReady && cacheEn && !fetchLock && lkHit) |=> (respValid && !memReqValid));

  assert_resp_has_cause_R1: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($past(fetchValid && fetchReady) || $past(memRspValid)));

endmodule

// File: rtl/icache_lockable.sv
module icache_lockable #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 32,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                cacheEn,
  input  logic                                unlockAll,
  input  logic                                invalidateAll,
  input  logic                                fetchValid,
  output logic                                fetchReady,
  input  logic                                fetchLock,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]  fetchAddr,
  output logic                                respValid,
  output logic [DATA_W-1:0]                   respData,
  output logic                                memReqValid,
  input  logic                                memReqReady,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]  memReqAddr,
  input  logic                                memRspValid,
  input  logic [DATA_W-1:0]                   memRspData
);

  localparam int WADDR_W = ADDR_W - $clog2(DATA_W/8);
  localparam int BEAT_W  = $clog2(LINE_WORDS);

  icache_pkg::dpStrobe_t stb;
  logic [BEAT_W-1:0]     fillBeat;
  logic                  lkHit;
  logic                  reqAlloc;
  logic [WADDR_W-1:0]    reqAddr;

  icache_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn),
    .fetchValid(fetchValid), .fetchLock(fetchLock),
    .lkHit(lkHit), .reqAlloc(reqAlloc), .reqAddr(reqAddr),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .fetchReady(fetchReady), .respValid(respValid),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .stb(stb), .fillBeat(fillBeat)
  );

  icache_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn),
    .unlockAll(unlockAll), .invalidateAll(invalidateAll),
    .fetchAddr(fetchAddr), .fetchLock(fetchLock),
    .stb(stb), .fillBeat(fillBeat), .memRspData(memRspData),
    .lkHit(lkHit), .reqAlloc(reqAlloc), .reqAddr(reqAddr),
    .respData(respData)
  );

endmodule

// File: tb/icache_lockable_tb.sv
module icache_lockable_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cacheEn = 1'b1;
  logic        unlockAll = 1'b0;
  logic        invalidateAll = 1'b0;
  logic        fetchValid = 1'b0;
  logic        fetchReady;
  logic        fetchLock = 1'b0;
  logic [29:0] fetchAddr = '0;
  logic        respValid;
  logic [31:0] respData;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [29:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  always #2 clk = ~clk;  // 250 MHz

  icache_lockable u_dut (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn),
    .unlockAll(unlockAll), .invalidateAll(invalidateAll),
    .fetchValid(fetchValid), .fetchReady(fetchReady),
    .fetchLock(fetchLock), .fetchAddr(fetchAddr),
    .respValid(respValid), .respData(respData),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  function automatic logic [31:0] memWord(input logic [29:0] wa);
    return {wa[15:0], ~wa[15:0]} ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- backing memory model ----------------
  logic [29:0] reqLog [16];
  int          logCnt = 0;
  bit          rspPend = 0;
  logic [29:0] pendAddr = '0;
  bit          stallPrev = 0;
  logic [29:0] stallAddr = '0;

  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (rspPend) begin
      memRspValid = 1'b1;
      memRspData  = memWord(pendAddr);
      rspPend     = 0;
    end
    if (stallPrev) begin
      // R12: a stalled request holds
      chk(memReqValid && memReqAddr == stallAddr, 12, "stalled request moved",
          {2'b0, memReqAddr}, {2'b0, stallAddr});
    end
    memReqReady = ~memReqReady;
    if (rstN && memReqValid && memReqReady) begin
      rspPend  = 1;
      pendAddr = memReqAddr;
      if (logCnt < 16) reqLog[logCnt] = memReqAddr;
      logCnt++;
    end
    stallPrev = rstN && memReqValid && !memReqReady;
    stallAddr = memReqAddr;
  end

  // ---------------- stimulus table ----------------
  typedef struct packed {
    logic [31:0] addr;   // byte address
    logic        lock;
    logic        en;
    logic [1:0]  cmd;    // 1 unlock pulse, 2 invalidate pulse before fetch
    logic [3:0]  reads;  // expected memory reads
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VEC [NV] = '{
    '{32'h0004, 1'b0, 1'b1, 2'd0, 4'd8, 4'd1},   // R1 cold miss, set 0 way0
    '{32'h0010, 1'b0, 1'b1, 2'd0, 4'd0, 4'd2},   // R2 same line hits
    '{32'h0400, 1'b0, 1'b1, 2'd0, 4'd8, 4'd4},   // R4 same set, way1
    '{32'h0800, 1'b0, 1'b1, 2'd0, 4'd8, 4'd4},   // way2
    '{32'h0C00, 1'b0, 1'b1, 2'd0, 4'd8, 4'd4},   // way3
    '{32'h0000, 1'b0, 1'b1, 2'd0, 4'd0, 4'd2},   // reuse 0x000
    '{32'h1000, 1'b0, 1'b1, 2'd0, 4'd8, 4'd5},   // R5 evicts way0
    '{32'h0000, 1'b0, 1'b1, 2'd0, 4'd8, 4'd5},   // R5 reused line gone; evicts way1
    '{32'h0400, 1'b0, 1'b1, 2'd0, 4'd8, 4'd5},   // evicts way2
    '{32'h0C04, 1'b0, 1'b1, 2'd0, 4'd0, 4'd5},   // way3 still present
    '{32'h0800, 1'b0, 1'b1, 2'd0, 4'd8, 4'd5},   // evicts way3
    '{32'h1000, 1'b0, 1'b1, 2'd0, 4'd0, 4'd5},   // way0 kept
    '{32'h0024, 1'b0, 1'b1, 2'd0, 4'd8, 4'd4},   // R4 set 1 independent
    '{32'h0028, 1'b0, 1'b0, 2'd0, 4'd1, 4'd6},   // R6 bypass though cached
    '{32'h0044, 1'b0, 1'b0, 2'd0, 4'd1, 4'd6},   // R6 bypass set 2
    '{32'h0044, 1'b0, 1'b1, 2'd0, 4'd8, 4'd6},   // R6 nothing allocated
    '{32'h0060, 1'b1, 1'b1, 2'd0, 4'd8, 4'd7},   // R7 lock-fill set 3 way0
    '{32'h0060, 1'b1, 1'b1, 2'd0, 4'd8, 4'd7},   // R7 refetch while present
    '{32'h0064, 1'b0, 1'b1, 2'd0, 4'd0, 4'd7},   // hit on pinned line
    '{32'h0460, 1'b0, 1'b1, 2'd0, 4'd8, 4'd7},   // way1
    '{32'h0860, 1'b0, 1'b1, 2'd0, 4'd8, 4'd7},   // way2
    '{32'h0C60, 1'b0, 1'b1, 2'd0, 4'd8, 4'd7},   // way3, pointer wraps to 0
    '{32'h1060, 1'b0, 1'b1, 2'd0, 4'd8, 4'd7},   // skips pinned way0, evicts way1
    '{32'h0060, 1'b0, 1'b1, 2'd0, 4'd0, 4'd7},   // pinned line survives
    '{32'h0460, 1'b0, 1'b1, 2'd0, 4'd8, 4'd5},   // evicted earlier, takes way2
    '{32'h0C60, 1'b0, 1'b1, 2'd0, 4'd0, 4'd5},   // way3 untouched
    '{32'h0080, 1'b1, 1'b1, 2'd0, 4'd8, 4'd7},   // pin set 4 way0
    '{32'h0480, 1'b1, 1'b1, 2'd0, 4'd8, 4'd7},   // way1
    '{32'h0880, 1'b1, 1'b1, 2'd0, 4'd8, 4'd7},   // way2
    '{32'h0C80, 1'b1, 1'b1, 2'd0, 4'd8, 4'd7},   // way3
    '{32'h1080, 1'b0, 1'b1, 2'd0, 4'd1, 4'd8},   // R8 all pinned: single read
    '{32'h1084, 1'b0, 1'b1, 2'd0, 4'd1, 4'd8},   // R8 not allocated
    '{32'h0484, 1'b0, 1'b1, 2'd0, 4'd0, 4'd8},   // pinned lines intact
    '{32'h1080, 1'b0, 1'b1, 2'd1, 4'd8, 4'd9},   // R9 unlock, then allocate way0
    '{32'h0480, 1'b0, 1'b1, 2'd0, 4'd0, 4'd9},   // R9 lines stay valid
    '{32'h0080, 1'b0, 1'b1, 2'd0, 4'd8, 4'd9},   // R9 formerly pinned line evicted
    '{32'h0024, 1'b0, 1'b1, 2'd2, 4'd8, 4'd10},  // R10 invalidate empties set 1
    '{32'h0060, 1'b0, 1'b1, 2'd0, 4'd8, 4'd10},  // R10 pin and valid gone
    '{32'h0460, 1'b0, 1'b1, 2'd0, 4'd8, 4'd10}   // R10
  };

  task automatic doFetch(input logic [31:0] byteAddr, input logic lock, input logic en,
                         input logic [1:0] cmd, input int reads, input int req);
    logic [29:0] wa;
    int lat;
    wa = byteAddr[31:2];
    @(negedge clk);
    cacheEn = en;
    if (cmd != 0) begin
      unlockAll     = (cmd == 2'd1);
      invalidateAll = (cmd == 2'd2);
      @(negedge clk);
      unlockAll     = 1'b0;
      invalidateAll = 1'b0;
    end
    chk(fetchReady, 3, "not ready before fetch", {31'b0, fetchReady}, 32'd1);
    logCnt     = 0;
    fetchAddr  = wa;
    fetchLock  = lock;
    fetchValid = 1'b1;
    @(negedge clk);
    fetchValid = 1'b0;
    fetchLock  = 1'b0;
    lat = 1;
    if (reads > 0)  // R3 busy during memory traffic
      chk(!fetchReady, 3, "ready during fill", {31'b0, fetchReady}, 32'd0);
    while (!respValid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(respValid, req, "no response", {31'b0, respValid}, 32'd1);
    chk(respData == memWord(wa), req, "response data", respData, memWord(wa));
    chk(logCnt == reads, req, "memory read count", logCnt, reads);
    if (reads == 0)  // R2 hit latency
      chk(lat == 1, 2, "hit latency", lat, 1);
    if (reads == 8 && logCnt == 8) begin
      for (int i = 0; i < 8; i++)  // R1 line-aligned ascending beats
        chk(reqLog[i] == {wa[29:3], 3'(i)}, 1, "fill address",
            {2'b0, reqLog[i]}, {2'b0, wa[29:3], 3'(i)});
    end
    if (reads == 1 && logCnt == 1)  // R6, R8 word address
      chk(reqLog[0] == wa, req, "single read address", {2'b0, reqLog[0]}, {2'b0, wa});
    @(negedge clk);
    chk(!respValid, req, "response longer than one cycle", {31'b0, respValid}, 32'd0);
  endtask

  task automatic checkIdleOutputs(input string what);
    chk(fetchReady, 11, what, {31'b0, fetchReady}, 32'd1);
    chk(!respValid, 11, what, {31'b0, respValid}, 32'd0);
    chk(!memReqValid, 11, what, {31'b0, memReqValid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdleOutputs("reset state");  // R11 during reset
    rstN = 1'b1;
    @(negedge clk);
    checkIdleOutputs("after reset");

    for (int v = 0; v < NV; v++)
      doFetch(VEC[v].addr, VEC[v].lock, VEC[v].en, VEC[v].cmd, VEC[v].reads, VEC[v].req);

    // R11: reset mid-run empties the cache and resets pointers
    doFetch(32'h2100, 1'b1, 1'b1, 2'd0, 8, 7);  // pin a line in set 8
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkIdleOutputs("reset mid-run");
    rstN = 1'b1;
    @(negedge clk);
    doFetch(32'h1000, 1'b0, 1'b1, 2'd0, 8, 11);  // line cached before reset is gone
    doFetch(32'h1004, 1'b0, 1'b1, 2'd0, 0, 11);
    doFetch(32'h2100, 1'b0, 1'b1, 2'd0, 8, 11);  // pin cleared by reset
    doFetch(32'h2500, 1'b0, 1'b1, 2'd0, 8, 11);  // set 8 fills way1, pointer from zero
    doFetch(32'h2900, 1'b0, 1'b1, 2'd0, 8, 11);
    doFetch(32'h2D00, 1'b0, 1'b1, 2'd0, 8, 11);
    doFetch(32'h3100, 1'b0, 1'b1, 2'd0, 8, 11);  // evicts way0 (0x2100): no pin left
    doFetch(32'h2100, 1'b0, 1'b1, 2'd0, 8, 11);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule